// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block forms the word a flash device places on its data bus while an internal program or erase is running, and the word it returns once that operation has finished. The command decoder, the array and the operation timer sit outside it and appear here as plain inputs. These inputs are a busy level, a flag that says whether the running operation is an erase, the latched true data of the word being written, and the word the array would return on an ordinary read.

The host reads by raising a read strobe. Each rising edge of the strobe counts as one read. While busy is high, a read never returns array contents. Bit 7 carries a completion poll. During a program this bit is the inverse of the target bit; during an erase it is held at zero. Bit 6 flips on every successive read. The remaining bits echo the latched target data. When busy drops, the next read returns the array word unaltered. The busy input is raised by the command logic only after the last write pulse of a program or erase sequence, so status reporting begins there.

The result is registered. It appears one clock after the strobe edge, together with a one-cycle valid pulse, and it holds until the next read.

Top module: `flash_poll_status`

## Requirements
- R1: During a program (op_busy=1, op_erase=0), a read returns bit 7 equal to the inverse of target_data bit 7.
- R2: During an erase (op_busy=1, op_erase=1), a read returns 0 on bit 7. After the erase ends, a read of an erased word (array_data=16'hFFFF) returns 1 on bit 7.
- R3: Within one operation, bit 6 of each busy read is the inverse of bit 6 of the previous busy read. The first busy read of an operation returns 0 on bit 6.
- R4: Bit 6 advances once per rising edge of rd_stb, however many cycles the strobe stays high.
- R5: When op_busy is low, a read returns array_data on all 16 bits, with no status bit altered. This includes the very first read after an operation completes.
- R6: rd_valid pulses high for exactly one cycle, one clock after the rising edge of rd_stb. rd_data changes only with that pulse and holds between reads.
- R7: During busy, every bit other than bits 7 and 6 equals the corresponding bit of target_data.
- R8: While rst is high, rd_data is 0 and rd_valid is 0 from the next clock edge onward.
- R9: A new operation (a rising edge of op_busy) restarts bit 6 at 0, whatever value the previous operation left. This holds also when the first read falls in the same cycle as the busy edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1: running operation is an erase, 0: a program |
| target_data | input | 16 | Latched true data of the word being written |
| array_data | input | 16 | Word the array returns on an ordinary read |
| rd_stb | input | 1 | Read strobe; each rising edge is one read |
| rd_data | output | 16 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking a new rd_data |

## Verification
Several rules are checked on every cycle by the assertions. These are the polling bit during program and erase, the echo of the other target bits, the unaltered array word when idle, the single-cycle valid pulse, and the restart of the toggle state when a new operation begins. Some behaviours only the bench scenarios can show. One is the alternation of bit 6 across a chain of reads. Another is that a long strobe counts once. A third is the restart when the first read lands on the busy edge itself. The last is the clean switch from status to array data on the first read after completion. For these, the bench's behavioural model is compared against the outputs on every clock.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  // Mode of the read currently being formed.
  typedef struct packed {
    logic active;  // operation in progress
    logic erase;   // erase rather than program
    logic tog;     // toggle value to present
  } wsr_mode_t;

endpackage

// File: rtl/wsr_strobe_edge.sv
module wsr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic hit
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  assign hit = stb & ~stb_q;

  // R4: a strobe held high yields no second hit
  a_r4_single_hit: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/wsr_toggle_track.sv
module wsr_toggle_track #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic hit,
  output logic tog_now
);
  logic busy_q;
  logic tog_q;
  logic start;

  assign start   = busy & ~busy_q;
  assign tog_now = start ? TOG_INIT : tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tog_q  <= TOG_INIT;
    end else begin
      busy_q <= busy;
      if (busy && hit) tog_q <= ~tog_now;
      else if (start)  tog_q <= TOG_INIT;
    end
  end

  // R9: a fresh operation with no read in its first cycle restarts the toggle
  a_r9_restart_init: assert property (@(posedge clk) disable iff (rst)
    (busy && !busy_q && !hit) |=> (tog_q == TOG_INIT));

  // R4: no read strobe edge and no new operation leaves the toggle alone
  a_r4_hold_no_read: assert property (@(posedge clk) disable iff (rst)
    (!hit && !(busy && !busy_q)) |=> $stable(tog_q));
endmodule

// File: rtl/wsr_status_mux.sv
module wsr_status_mux
  import wsr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  wsr_mode_t         mode,
  input  logic [DATA_W-1:0] tdat,
  input  logic [DATA_W-1:0] adat,
  output logic [DATA_W-1:0] word
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign word[i] = mode.active ? (mode.erase ? 1'b0 : ~tdat[i]) : adat[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign word[i] = mode.active ? mode.tog : adat[i];
    end else begin : g_plain
      assign word[i] = mode.active ? tdat[i] : adat[i];
    end
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import wsr_pkg::*;
#(
  parameter int   DATA_W   = 16,
  parameter int   POLL_BIT = 7,
  parameter int   TOG_BIT  = 6,
  parameter logic TOG_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_busy,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] target_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);
  localparam logic [DATA_W-1:0] OTHER_MASK = ~STATUS_MASK;

  logic              hit;
  logic              tog_now;
  wsr_mode_t         mode;
  logic [DATA_W-1:0] formed;

  wsr_strobe_edge u_edge (
    .clk (clk),
    .rst (rst),
    .stb (rd_stb),
    .hit (hit)
  );

  wsr_toggle_track #(.TOG_INIT(TOG_INIT)) u_tog (
    .clk     (clk),
    .rst     (rst),
    .busy    (op_busy),
    .hit     (hit),
    .tog_now (tog_now)
  );

  assign mode = '{active: op_busy, erase: op_erase, tog: tog_now};

  wsr_status_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
    .mode (mode),
    .tdat (target_data),
    .adat (array_data),
    .word (formed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= hit;
      if (hit) rd_data <= formed;
    end
  end

  a_r1_program_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(op_busy) && !$past(op_erase))
      |-> (rd_data[POLL_BIT] == ~$past(target_data[POLL_BIT])));

  a_r2_erase_poll_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(op_busy) && $past(op_erase)) |-> (rd_data[POLL_BIT] == 1'b0));

  a_r7_other_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(op_busy))
      |-> ((rd_data & OTHER_MASK) == ($past(target_data) & OTHER_MASK)));

  a_r5_idle_array: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !$past(op_busy)) |-> (rd_data == $past(array_data)));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && !$past(rst)) |-> $stable(rd_data));
endmodule

// File: tb/flash_poll_status_bench.sv
module flash_poll_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_busy = 1'b0;
  logic        op_erase = 1'b0;
  logic [15:0] target_data = '0;
  logic [15:0] array_data = '0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  string tag6 = "R3";

  always #10 clk = ~clk;

  flash_poll_status u_flash_poll_status (
    .clk(clk), .rst(rst), .op_busy(op_busy), .op_erase(op_erase),
    .target_data(target_data), .array_data(array_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Behavioural reference model, updated at each rising edge
  logic [15:0] exp_data = '0;
  bit          exp_valid = 0;
  bit          m_pstb = 0, m_pbusy = 0, m_tog = 0;
  bit          m_from_busy = 0, m_erase = 0, m_reset = 1, started = 0;
  string       m_tag6 = "R3";

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      exp_data = '0; exp_valid = 0; m_tog = 0; m_pstb = 0; m_pbusy = 0;
      m_reset = 1;
    end else begin
      bit rise, start;
      m_reset = 0;
      rise  = rd_stb && !m_pstb;
      start = op_busy && !m_pbusy;
      if (start) m_tog = 0;
      exp_valid = rise;
      if (rise) begin
        m_from_busy = op_busy;
        m_erase = op_erase;
        m_tag6 = tag6;
        if (op_busy) begin
          exp_data = target_data;
          exp_data[7] = op_erase ? 1'b0 : ~target_data[7];
          exp_data[6] = m_tog;
          m_tog = !m_tog;
        end else begin
          exp_data = array_data;
        end
      end
      m_pstb = rd_stb;
      m_pbusy = op_busy;
    end
  end

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at t=%0t", req, what, got, exp, $time);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      if (m_reset) begin
        check("R8", "rd_valid", {15'd0, rd_valid}, 16'd0);
        check("R8", "rd_data", rd_data, 16'd0);
      end else begin
        check("R6", "rd_valid", {15'd0, rd_valid}, {15'd0, exp_valid});
        if (exp_valid && m_from_busy) begin
          check(m_erase ? "R2" : "R1", "poll bit", {15'd0, rd_data[7]}, {15'd0, exp_data[7]});
          check(m_tag6, "toggle bit", {15'd0, rd_data[6]}, {15'd0, exp_data[6]});
          check("R7", "other bits", rd_data & 16'hFF3F, exp_data & 16'hFF3F);
        end else if (exp_valid) begin
          check(m_erase ? "R2" : "R5", "idle word", rd_data, exp_data);
        end else begin
          check("R6", "held word", rd_data, exp_data);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(int hold);
    rd_stb = 1'b1;
    tick(hold);
    rd_stb = 1'b0;
    tick(2);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
        done = 1;
      end
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    // R5: idle reads show the array word unchanged
    array_data = 16'h12C0; do_read(1);
    array_data = 16'h0080; do_read(1);
    // R1/R3/R7: program, toggling reads, bit 7 both ways
    op_erase = 1'b0; target_data = 16'hA5C3; op_busy = 1'b1; tick(2);
    do_read(1); do_read(1);
    target_data = 16'h5A3C; do_read(1); do_read(1); do_read(3);
    // R4: a long strobe counts once
    tag6 = "R4";
    do_read(9); do_read(1);
    tag6 = "R3";
    // R5: first read after completion returns array data
    op_busy = 1'b0; array_data = 16'hA5C3; tick(1); do_read(1);
    // R2/R9: erase restarts toggle; then erased word reads 1 on bit 7
    tag6 = "R9"; op_erase = 1'b1; target_data = 16'hFFFF; op_busy = 1'b1; tick(1);
    do_read(1);
    tag6 = "R3"; do_read(1); do_read(1);
    op_busy = 1'b0; array_data = 16'hFFFF; tick(1); do_read(1);
    // R9: read on the very cycle busy rises
    tag6 = "R9"; op_erase = 1'b0; target_data = 16'h0F7E;
    op_busy = 1'b1; rd_stb = 1'b1; tick(1); rd_stb = 1'b0; tick(2);
    tag6 = "R3"; do_read(1); do_read(2);
    // R8: reset mid-operation clears outputs
    rst = 1'b1; tick(3); rst = 1'b0; op_busy = 1'b0; tick(2);
    array_data = 16'h3333; do_read(1);
    tick(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule